// File: doc/BRIEF.md
# Rate-Adjustable Time Counter

This block keeps a 64-bit time count whose unit is one 8 ns tick. A 32-bit rate word sets how fast the count moves. The word is read as a ratio to 2^31, and its fractional remainder is kept in a phase accumulator from cycle to cycle. The count can therefore be slowed or sped up by a few percent to track a remote time reference.

Software reaches the block through a simple single-cycle register port. The count can be read, and the read returns both 32-bit halves as one coherent value. A 64-bit value write either overwrites the count or adds a signed correction to it. Which of the two happens depends on a mode bit held in a packed command word. The same command word also:
- clears the clock,
- starts or stops the schedule flag,
- fires one-cycle start and stop strobes toward an output pin,
- holds an option flag that marks whether timestamps are corrected.

Top module: `ptc_time_counter`

## Requirements
- R1: While `rst` is high and after its release, the count is 0 and the rate register reads 0x8000_0000. The status word reads 0x0000_0002: set mode, correction option on, schedule stopped. Both pin strobes are low.
- R2: At the nominal rate 0x8000_0000 the count rises by exactly one per cycle. `time_ns` always equals 8 times `time_now`.
- R3: Each cycle the count rises by the integer part of (31-bit phase + rate) / 2^31, and the remainder becomes the new phase. With rate 0x8400_0000, starting from phase 0, the count gains 33 in 32 cycles.
- R4: A write to address 1 stores the rate clamped to the range [0x7BE7_6C8C, 0x8418_9374], which is about ±3.2% around nominal. A read of address 1 returns the stored value.
- R5: A write to address 2 stages the low 32 bits of a clock value. A write to address 3 supplies the high 32 bits and commits the 64-bit value. In set mode (mode bit 0), the count after that edge equals the value, and the tick of that cycle is dropped.
- R6: In add mode (mode bit 1), the commit adds the value to the count as a signed two's-complement delta, on top of that cycle's tick.
- R7: A write to address 0 is a command. Its bit positions are: valid 31, schedule start 30, schedule stop 29, pin start 28, pin stop 27, clear 2, correction option 1, add mode 0. A command whose valid bit is 0 changes nothing.
- R8: A valid command with the clear bit set zeroes the count and the phase. It also forces set mode and turns the correction option on, whatever bits 1 and 0 of that word hold.
- R9: The schedule start bit sets `sched_run` and the schedule stop bit clears it. When both bits are set in one command, stop wins.
- R10: The pin start and pin stop bits each produce a `pin_start` / `pin_stop` pulse lasting exactly the one cycle after the command.
- R11: A valid command without clear loads the mode bit and the correction option from bits 0 and 1. Both then hold their value until the next valid command.
- R12: `rd_data` is registered one cycle after `rd_en`:
  - address 0 returns the status word: bit 30 schedule, bit 1 correction option, bit 0 mode, other bits 0.
  - address 1 returns the rate.
  - address 2 returns the low half of the count and captures the high half at the same time.
  - address 3 returns that captured high half, even if the count has since changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| time_now | output | 64 | Current count in ticks |
| time_ns | output | 64 | Current count in nanoseconds |
| sched_run | output | 1 | Schedule running flag |
| pin_start | output | 1 | One-cycle pin start strobe |
| pin_stop | output | 1 | One-cycle pin stop strobe |
| corr_ts | output | 1 | Timestamp correction option |

## Verification
The ongoing tick and a software value write meet in the same cycle whenever a value commit lands. In set mode that cycle's tick must be dropped; in add mode it must be kept on top of the delta. A clear command likewise collides with the tick and must win. These collisions are provoked by directed writes, including negative deltas. Random command, rate and value writes then land on running counts at non-zero phases. Each outcome is judged cycle by cycle against a bench model of the count, the phase and the registers.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    localparam int DATA_W     = 32;
    localparam int REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] ADDR_CMD    = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_RATE   = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_VAL_LO = 2'd2;
    localparam logic [REG_ADDR_W-1:0] ADDR_VAL_HI = 2'd3;

    // command word bit positions (decoded by software, so fixed)
    localparam int B_VALID       = 31;
    localparam int B_SCHED_START = 30;
    localparam int B_SCHED_STOP  = 29;
    localparam int B_PIN_START   = 28;
    localparam int B_PIN_STOP    = 27;
    localparam int B_CLEAR       = 2;
    localparam int B_CORR        = 1;
    localparam int B_ADD         = 0;

    // status word positions
    localparam int S_SCHED = 30;
    localparam int S_CORR  = 1;
    localparam int S_MODE  = 0;

    typedef enum logic {
        MODE_SET = 1'b0,
        MODE_ADD = 1'b1
    } wr_mode_e;

    typedef struct packed {
        logic valid;
        logic sched_start;
        logic sched_stop;
        logic pin_start;
        logic pin_stop;
        logic clear;
        logic corr;
        logic add;
    } cmd_t;

    function automatic cmd_t cmd_decode(input logic [DATA_W-1:0] w);
        cmd_t c;
        c.valid       = w[B_VALID];
        c.sched_start = w[B_SCHED_START];
        c.sched_stop  = w[B_SCHED_STOP];
        c.pin_start   = w[B_PIN_START];
        c.pin_stop    = w[B_PIN_STOP];
        c.clear       = w[B_CLEAR];
        c.corr        = w[B_CORR];
        c.add         = w[B_ADD];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] rate_clamp(
        input logic [DATA_W-1:0] v,
        input logic [DATA_W-1:0] lo,
        input logic [DATA_W-1:0] hi
    );
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

endpackage

// File: rtl/ptc_ctrl_regs.sv
module ptc_ctrl_regs
    import ptc_pkg::*;
#(
    parameter logic [DATA_W-1:0] RATE_SPAN = 32'h0418_9374
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [REG_ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [DATA_W-1:0]       rate_q,
    output wr_mode_e                mode_q,
    output logic                    corr_q,
    output logic                    sched_q,
    output logic                    pin_start_q,
    output logic                    pin_stop_q,
    output logic                    clear_now,
    output logic                    value_wr_now,
    output logic [2*DATA_W-1:0]     value_word
);
    localparam logic [DATA_W-1:0] RATE_NOM = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] RATE_MIN = RATE_NOM - RATE_SPAN;
    localparam logic [DATA_W-1:0] RATE_MAX = RATE_NOM + RATE_SPAN;

    cmd_t              cmd;
    logic              cmd_hit;
    logic [DATA_W-1:0] lo_stage_q;

    always_comb begin
        cmd          = cmd_decode(wr_data);
        cmd_hit      = wr_en && (wr_addr == ADDR_CMD) && cmd.valid;
        clear_now    = cmd_hit && cmd.clear;
        value_wr_now = wr_en && (wr_addr == ADDR_VAL_HI);
        value_word   = {wr_data, lo_stage_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q      <= RATE_NOM;
            mode_q      <= MODE_SET;
            corr_q      <= 1'b1;
            sched_q     <= 1'b0;
            pin_start_q <= 1'b0;
            pin_stop_q  <= 1'b0;
            lo_stage_q  <= '0;
        end else begin
            pin_start_q <= cmd_hit && cmd.pin_start;
            pin_stop_q  <= cmd_hit && cmd.pin_stop;
            if (cmd_hit) begin
                if (cmd.clear) begin
                    mode_q <= MODE_SET;
                    corr_q <= 1'b1;
                end else begin
                    mode_q <= wr_mode_e'(cmd.add);
                    corr_q <= cmd.corr;
                end
                if (cmd.sched_start) sched_q <= 1'b1;
                if (cmd.sched_stop)  sched_q <= 1'b0;
            end
            if (wr_en && (wr_addr == ADDR_RATE))
                rate_q <= rate_clamp(wr_data, RATE_MIN, RATE_MAX);
            if (wr_en && (wr_addr == ADDR_VAL_LO))
                lo_stage_q <= wr_data;
        end
    end

endmodule

// File: rtl/ptc_phase_acc.sv
module ptc_phase_acc #(
    parameter int RATE_W = 32,
    parameter int FRAC_W = RATE_W - 1,
    localparam int INC_W = RATE_W + 1 - FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [RATE_W-1:0] rate,
    output logic [INC_W-1:0]  inc
);
    logic [FRAC_W-1:0] phase_q;
    logic [RATE_W:0]   sum;

    always_comb begin
        sum = {{INC_W{1'b0}}, phase_q} + {1'b0, rate};
        inc = sum[RATE_W:FRAC_W];
    end

    always_ff @(posedge clk) begin
        if (rst || clear) phase_q <= '0;
        else              phase_q <= sum[FRAC_W-1:0];
    end

endmodule

// File: rtl/ptc_time_core.sv
module ptc_time_core
    import ptc_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int INC_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [INC_W-1:0] inc,
    input  logic             value_wr,
    input  wr_mode_e         mode,
    input  logic [CNT_W-1:0] value,
    output logic [CNT_W-1:0] count_q
);
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] next;

    always_comb begin
        step = count_q + CNT_W'(inc);
        if (clear)
            next = '0;
        else if (value_wr)
            next = (mode == MODE_ADD) ? (step + value) : value;
        else
            next = step;
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= next;
    end

endmodule

// File: rtl/ptc_readback.sv
module ptc_readback
    import ptc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_en,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    input  logic [2*DATA_W-1:0]   count,
    input  logic [DATA_W-1:0]     rate,
    input  logic [DATA_W-1:0]     status,
    output logic [DATA_W-1:0]     rd_data
);
    logic [DATA_W-1:0] snap_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '0;
            snap_hi_q <= '0;
        end else if (rd_en) begin
            unique case (rd_addr)
                ADDR_CMD:  rd_data <= status;
                ADDR_RATE: rd_data <= rate;
                ADDR_VAL_LO: begin
                    rd_data   <= count[DATA_W-1:0];
                    snap_hi_q <= count[2*DATA_W-1:DATA_W];
                end
                default:   rd_data <= snap_hi_q;
            endcase
        end
    end

endmodule

// File: rtl/ptc_time_counter.sv
module ptc_time_counter
    import ptc_pkg::*;
#(
    parameter logic [DATA_W-1:0] RATE_SPAN    = 32'h0418_9374,
    parameter int                TICK_NS_LOG2 = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  rd_en,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    output logic [2*DATA_W-1:0]   time_now,
    output logic [2*DATA_W-1:0]   time_ns,
    output logic                  sched_run,
    output logic                  pin_start,
    output logic                  pin_stop,
    output logic                  corr_ts
);
    localparam int CNT_W  = 2 * DATA_W;
    localparam int FRAC_W = DATA_W - 1;
    localparam int INC_W  = DATA_W + 1 - FRAC_W;

    logic [DATA_W-1:0] rate_q;
    wr_mode_e          mode_q;
    logic              corr_q;
    logic              sched_q;
    logic              clear_now;
    logic              value_wr_now;
    logic [CNT_W-1:0]  value_word;
    logic [INC_W-1:0]  inc;
    logic [CNT_W-1:0]  count_q;
    logic [DATA_W-1:0] status;

    ptc_ctrl_regs #(.RATE_SPAN(RATE_SPAN)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rate_q       (rate_q),
        .mode_q       (mode_q),
        .corr_q       (corr_q),
        .sched_q      (sched_q),
        .pin_start_q  (pin_start),
        .pin_stop_q   (pin_stop),
        .clear_now    (clear_now),
        .value_wr_now (value_wr_now),
        .value_word   (value_word)
    );

    ptc_phase_acc #(.RATE_W(DATA_W), .FRAC_W(FRAC_W)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .clear (clear_now),
        .rate  (rate_q),
        .inc   (inc)
    );

    ptc_time_core #(.CNT_W(CNT_W), .INC_W(INC_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear_now),
        .inc      (inc),
        .value_wr (value_wr_now),
        .mode     (mode_q),
        .value    (value_word),
        .count_q  (count_q)
    );

    always_comb begin
        status         = '0;
        status[S_SCHED] = sched_q;
        status[S_CORR]  = corr_q;
        status[S_MODE]  = mode_q;
    end

    ptc_readback u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .count   (count_q),
        .rate    (rate_q),
        .status  (status),
        .rd_data (rd_data)
    );

    assign time_now  = count_q;
    assign time_ns   = count_q << TICK_NS_LOG2;
    assign sched_run = sched_q;
    assign corr_ts   = corr_q;

endmodule

// File: rtl/ptc_checker.sv
module ptc_checker
    import ptc_pkg::*;
#(
    parameter logic [DATA_W-1:0] RATE_SPAN = 32'h0418_9374
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [REG_ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0]     wr_data,
    input logic [2*DATA_W-1:0]   time_now,
    input logic                  sched_run,
    input logic                  pin_start,
    input logic [DATA_W-1:0]     rate_q
);
    localparam logic [DATA_W-1:0] NOM = {1'b1, {(DATA_W-1){1'b0}}};

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R4: stored rate never leaves the clamp window
    always @(posedge clk) begin
        if (!rst) begin
            a_r4_rate_in_window: assert (rate_q >= NOM - RATE_SPAN && rate_q <= NOM + RATE_SPAN);
        end
    end

    // R3: without a software write the count moves by at most two ticks
    a_r3_step_bounded: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(wr_en)) |-> ((time_now - $past(time_now)) <= 64'd2));

    // R8: a valid clear command leaves the count at zero
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(wr_en && wr_addr == ADDR_CMD && wr_data[B_VALID] && wr_data[B_CLEAR]))
        |-> (time_now == '0));

    // R10: a pin start pulse only follows a valid command with that bit
    a_r10_pin_start_cause: assert property (@(posedge clk) disable iff (rst)
        pin_start |-> (armed && $past(wr_en && wr_addr == ADDR_CMD
                                      && wr_data[B_VALID] && wr_data[B_PIN_START])));

    // R9: a stop request always leaves the schedule stopped
    a_r9_stop_wins: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(wr_en && wr_addr == ADDR_CMD && wr_data[B_VALID] && wr_data[B_SCHED_STOP]))
        |-> !sched_run);

endmodule

bind ptc_time_counter ptc_checker #(.RATE_SPAN(RATE_SPAN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .time_now  (time_now),
    .sched_run (sched_run),
    .pin_start (pin_start),
    .rate_q    (rate_q)
);

// File: tb/tb_ptc_time_counter.sv
module tb_ptc_time_counter;
    localparam logic [31:0] NOM  = 32'h8000_0000;
    localparam logic [31:0] RMIN = 32'h7BE7_6C8C;
    localparam logic [31:0] RMAX = 32'h8418_9374;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [63:0] time_now, time_ns;
    logic        sched_run, pin_start, pin_stop, corr_ts;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit live   = 1'b0;

    always #5 clk = ~clk;

    ptc_time_counter dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .time_now(time_now),
        .time_ns(time_ns), .sched_run(sched_run), .pin_start(pin_start),
        .pin_stop(pin_stop), .corr_ts(corr_ts)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] clampf(input logic [31:0] v);
        if (v < RMIN) return RMIN;
        if (v > RMAX) return RMAX;
        return v;
    endfunction

    // behavioural model of the requirements
    logic [30:0] m_ph;
    logic [63:0] m_cnt;
    logic [31:0] m_rate, m_lo, m_snap, m_rd;
    logic        m_mode, m_corr, m_sched, m_ps, m_pp;

    always @(posedge clk) begin
        logic [32:0] s;
        logic [63:0] nc;
        logic [30:0] np;
        if (rst) begin
            m_ph = '0; m_cnt = '0; m_rate = NOM; m_lo = '0; m_snap = '0; m_rd = '0;
            m_mode = 1'b0; m_corr = 1'b1; m_sched = 1'b0; m_ps = 1'b0; m_pp = 1'b0;
        end else begin
            s  = {2'b00, m_ph} + {1'b0, m_rate};
            nc = m_cnt + 64'(s[32:31]);
            np = s[30:0];
            if (rd_en) begin
                case (rd_addr)
                    2'd0: m_rd = {1'b0, m_sched, 28'd0, m_corr, m_mode};
                    2'd1: m_rd = m_rate;
                    2'd2: begin m_rd = m_cnt[31:0]; m_snap = m_cnt[63:32]; end
                    default: m_rd = m_snap;
                endcase
            end
            m_ps = 1'b0; m_pp = 1'b0;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: if (wr_data[31]) begin
                        if (wr_data[2]) begin
                            nc = '0; np = '0; m_mode = 1'b0; m_corr = 1'b1;
                        end else begin
                            m_mode = wr_data[0]; m_corr = wr_data[1];
                        end
                        if (wr_data[30]) m_sched = 1'b1;
                        if (wr_data[29]) m_sched = 1'b0;
                        m_ps = wr_data[28]; m_pp = wr_data[27];
                    end
                    2'd1: m_rate = clampf(wr_data);
                    2'd2: m_lo = wr_data;
                    default: nc = m_mode ? (nc + {wr_data, m_lo}) : {wr_data, m_lo};
                endcase
            end
            m_cnt = nc; m_ph = np;
        end
    end

    // continuous comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (live && !rst) begin
            chk(time_now == m_cnt, "R5/R6 count", time_now, m_cnt);
            chk(time_ns == (m_cnt << 3), "R2 ns", time_ns, m_cnt << 3);
            chk(rd_data == m_rd, "R12 rd_data", 64'(rd_data), 64'(m_rd));
            chk(sched_run == m_sched, "R9 sched", 64'(sched_run), 64'(m_sched));
            chk({pin_start, pin_stop} == {m_ps, m_pp}, "R10 pins",
                64'({pin_start, pin_stop}), 64'({m_ps, m_pp}));
            chk(corr_ts == m_corr, "R11 corr", 64'(corr_ts), 64'(m_corr));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] t0;
        logic [31:0] hi0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(time_now == 0, "R1 count", time_now, 0);
        chk(corr_ts == 1'b1 && sched_run == 1'b0 && !pin_start && !pin_stop, "R1 flags",
            64'({corr_ts, sched_run, pin_start, pin_stop}), 64'b1000);
        rst = 1'b0;
        live = 1'b1;
        rd(2'd1);
        chk(rd_data == NOM, "R1 rate", 64'(rd_data), 64'(NOM));
        rd(2'd0);
        chk(rd_data == 32'h2, "R1 status", 64'(rd_data), 64'h2);
        // R2 nominal rate
        t0 = time_now;
        repeat (10) @(negedge clk);
        chk(time_now - t0 == 10, "R2 nominal", time_now - t0, 10);
        // R7 invalid command ignored
        t0 = time_now;
        wr(2'd0, 32'h7800_0007);
        chk(time_now == t0 + 1, "R7 ignored count", time_now, t0 + 1);
        chk(!pin_start && !sched_run, "R7 ignored flags", 64'({pin_start, sched_run}), 0);
        rd(2'd0);
        chk(rd_data == 32'h2, "R7 ignored status", 64'(rd_data), 64'h2);
        // R5 set-mode load, tick of commit cycle dropped
        wr(2'd2, 32'h0000_1234);
        wr(2'd3, 32'h0000_0001);
        chk(time_now == 64'h1_0000_1234, "R5 load", time_now, 64'h1_0000_1234);
        // R6 add mode, positive and negative deltas
        wr(2'd0, 32'h8000_0003);
        chk(corr_ts == 1'b1, "R11 corr held", 64'(corr_ts), 1);
        wr(2'd2, 32'd5);
        t0 = time_now;
        wr(2'd3, 32'd0);
        chk(time_now == t0 + 6, "R6 add +5", time_now, t0 + 6);
        wr(2'd2, 32'hFFFF_FFF6);
        t0 = time_now;
        wr(2'd3, 32'hFFFF_FFFF);
        chk(time_now == t0 - 9, "R6 add -10", time_now, t0 - 9);
        // R11 mode held: still add mode after idle cycles
        repeat (4) @(negedge clk);
        rd(2'd0);
        chk(rd_data == 32'h3, "R11 status", 64'(rd_data), 64'h3);
        // R12 coherent read
        wr(2'd0, 32'h8000_0002);
        hi0 = time_now[63:32];
        rd(2'd2);
        wr(2'd2, 32'h0);
        wr(2'd3, 32'hDEAD_BEEF);
        rd(2'd3);
        chk(rd_data == hi0, "R12 coherent hi", 64'(rd_data), 64'(hi0));
        // R9 schedule start, then start+stop together
        wr(2'd0, 32'hC000_0002);
        chk(sched_run == 1'b1, "R9 start", 64'(sched_run), 1);
        wr(2'd0, 32'hE000_0002);
        chk(sched_run == 1'b0, "R9 stop wins", 64'(sched_run), 0);
        // R10 pin strobes
        wr(2'd0, 32'h9800_0002);
        chk(pin_start && pin_stop, "R10 pulse", 64'({pin_start, pin_stop}), 64'b11);
        @(negedge clk);
        chk(!pin_start && !pin_stop, "R10 one cycle", 64'({pin_start, pin_stop}), 0);
        // R8 clear overrides mode and corr bits
        wr(2'd0, 32'h8000_0001);
        wr(2'd0, 32'h8000_0005);
        chk(time_now == 0, "R8 clear", time_now, 0);
        rd(2'd0);
        chk(rd_data == 32'h2, "R8 status", 64'(rd_data), 64'h2);
        // R4 clamp
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1);
        chk(rd_data == RMAX, "R4 clamp high", 64'(rd_data), 64'(RMAX));
        wr(2'd1, 32'h0);
        rd(2'd1);
        chk(rd_data == RMIN, "R4 clamp low", 64'(rd_data), 64'(RMIN));
        // R3 fractional rate: 33 ticks in 32 cycles from phase 0
        wr(2'd1, NOM);
        wr(2'd0, 32'h8000_0006);
        wr(2'd1, 32'h8400_0000);
        t0 = time_now;
        repeat (32) @(negedge clk);
        chk(time_now - t0 == 33, "R3 fractional", time_now - t0, 33);
        // random mix, checked by the model every cycle
        for (int i = 0; i < 3000; i++) begin
            int unsigned op;
            op = $urandom % 8;
            rd_en = ($urandom % 3) == 0;
            rd_addr = 2'($urandom);
            wr_en = op < 5;
            case (op)
                0: begin
                    wr_addr = 2'd0;
                    wr_data = $urandom & 32'hF800_0003;
                    if (($urandom % 8) == 0) wr_data[2] = 1'b1;
                    if (($urandom % 6) == 0) wr_data[31] = 1'b0;
                end
                1: begin wr_addr = 2'd1; wr_data = NOM - 32'h0500_0000 + ($urandom % 32'h0A00_0000); end
                2: begin wr_addr = 2'd2; wr_data = $urandom; end
                3: begin wr_addr = 2'd3; wr_data = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : ($urandom % 16); end
                default: begin wr_addr = 2'd0; wr_data = 32'h8000_0000 | ($urandom & 32'h3); end
            endcase
            @(negedge clk);
            wr_en = 1'b0;
            rd_en = 1'b0;
        end
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule